// File: doc/BRIEF.md
# Masked-Write Reset Control Bank

This block holds a set of reset-control words behind a simple 32-bit register bus and drives one reset line per stored bit. Each word carries 16 lines. Software can set or clear any group of lines in one word with a single store and no read-modify-write. The upper half of every write is a per-bit enable for the lower half, so two agents that touch different lines of the same word can never undo each other's update.

A store at byte address `4*n` updates word `n`. Where enable bit `16+i` is one, line bit `i` takes data bit `i`; every other bit keeps its value. A one in a stored bit means the line is asserted. A load returns the word in its low half, with zeros above, one cycle after the request. Line 0 is the whole-system reset, and a restart is two stores: one that asserts it and one that releases it. All outputs come straight from flops, so they cannot glitch. After power-on reset they take the value set by a parameter.

The block has no sequencing state of its own. Its only states are the reset-phase values of the stored words and the registered read word. The transitions are masked write, read capture and power-on reset.

Top module: `hwmask_reset_bank`

## Requirements
- R1: While and after `rst_n` is low, `rst_lines` equals `RESET_INIT` (default all zeros, meaning all released) and `bus_rdata` is 0.
- R2: Line k is bit k%16 of word k/16, and that word sits at byte address (k/16)*4. `rst_lines[k]` is the stored bit.
- R3: A write to a mapped word sets each bit i whose enable `bus_wdata[16+i]` is 1 to `bus_wdata[i]`, and leaves every bit whose enable is 0 unchanged. The new value appears on `rst_lines` right after the clock edge that accepts the write.
- R4: A write whose enable half `bus_wdata[31:16]` is zero changes no line.
- R5: A read of a mapped word returns its 16 bits in `bus_rdata[15:0]` and zeros in `bus_rdata[31:16]`, in the cycle after `bus_rd`. `bus_rdata` holds its value while `bus_rd` is low.
- R6: A write to an address with nonzero `bus_addr[1:0]`, or with word index `bus_addr[ADDR_W-1:2]` of `NUM_REGS` or more, changes no line.
- R7: A read of such an unmapped address returns 0.
- R8: A write to one word leaves the lines of every other word unchanged.
- R9: A write to address 0 with data 0x0001_0001 asserts line 0 alone, and a following write with 0x0001_0000 releases it. This is the restart sequence, and all other lines keep their values through it.
- R10: When a read and a write to the same word fall in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, synchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | [31:16] per-bit enables, [15:0] new line values |
| bus_rdata | output | 32 | Registered read word |
| rst_lines | output | NUM_REGS*16 | Registered reset outputs, 1 = asserted |

## Verification
The checker assumes that each strobe lasts one cycle and that `bus_addr` and `bus_wdata` are stable while it is high. It also assumes that nothing but the bus changes the stored words. The bench drives every access on the falling clock edge and holds it for exactly one cycle. Its random addresses cover the full `ADDR_W` range, so misaligned and out-of-range accesses occur often. Random enable masks include all-zero and all-one patterns.

// File: rtl/hwrb_pkg.sv
package hwrb_pkg;
    localparam int LANE_W = 16;
    localparam int BUS_W  = 32;
    typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/hwrb_decode.sv
module hwrb_decode #(
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 10,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [IDX_W-1:0]    idx,
    output logic [NUM_REGS-1:0] sel
);
    always_comb begin
        idx = addr[ADDR_W-1:2];
        hit = (addr[1:0] == 2'b00) && ({1'b0, idx} < (IDX_W+1)'(NUM_REGS));
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
        assign sel[r] = hit && (idx == IDX_W'(r));
    end
endmodule

// File: rtl/hwrb_word.sv
module hwrb_word
    import hwrb_pkg::*;
#(
    parameter lane_t INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [BUS_W-1:0] wdata,
    output lane_t            q
);
    lane_t en_mask;
    lane_t new_val;

    always_comb begin
        en_mask = wdata[BUS_W-1:LANE_W];
        new_val = (q & ~en_mask) | (wdata[LANE_W-1:0] & en_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (we) begin
            q <= new_val;
        end
    end
endmodule

// File: rtl/hwrb_rdmux.sv
module hwrb_rdmux
    import hwrb_pkg::*;
#(
    parameter int NUM_REGS = 10,
    parameter int IDX_W    = 4
) (
    input  logic [NUM_REGS*LANE_W-1:0] words,
    input  logic                       hit,
    input  logic [IDX_W-1:0]           idx,
    output lane_t                      word
);
    always_comb begin
        word = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (hit && (idx == IDX_W'(r))) begin
                word = words[r*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/hwmask_reset_bank.sv
module hwmask_reset_bank
    import hwrb_pkg::*;
#(
    parameter int NUM_REGS = 10,
    parameter int ADDR_W   = 6,
    parameter logic [NUM_REGS*16-1:0] RESET_INIT = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [BUS_W-1:0]         bus_rdata,
    output logic [NUM_REGS*16-1:0]   rst_lines
);
    localparam int IDX_W = ADDR_W - 2;

    logic                dec_hit;
    logic [IDX_W-1:0]    dec_idx;
    logic [NUM_REGS-1:0] dec_sel;
    lane_t               rd_word;

    hwrb_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .addr(bus_addr), .hit(dec_hit), .idx(dec_idx), .sel(dec_sel)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        hwrb_word #(.INIT(RESET_INIT[r*LANE_W +: LANE_W])) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_wr && dec_sel[r]),
            .wdata (bus_wdata),
            .q     (rst_lines[r*LANE_W +: LANE_W])
        );
    end

    hwrb_rdmux #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rdmux (
        .words(rst_lines), .hit(dec_hit), .idx(dec_idx), .word(rd_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= {{(BUS_W-LANE_W){1'b0}}, rd_word};
        end
    end
endmodule

// File: rtl/hwrb_checker.sv
module hwrb_checker #(
    parameter int NUM_REGS = 10,
    parameter int ADDR_W   = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_wdata,
    input logic [31:0]            bus_rdata,
    input logic [NUM_REGS*16-1:0] rst_lines
);
    logic        mapped;
    int          cur_base;
    logic        chk_valid;
    int          chk_base;
    logic [15:0] chk_exp;

    always_comb begin
        mapped   = (bus_addr[1:0] == 2'b00) && (int'(bus_addr >> 2) < NUM_REGS);
        cur_base = mapped ? int'(bus_addr >> 2) * 16 : 0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid <= 1'b0;
            chk_base  <= 0;
            chk_exp   <= '0;
        end else begin
            chk_valid <= bus_wr && mapped;
            chk_base  <= cur_base;
            chk_exp   <= (rst_lines[cur_base +: 16] & ~bus_wdata[31:16])
                       | (bus_wdata[15:0] & bus_wdata[31:16]);
        end
    end

    p_masked_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> (rst_lines[chk_base +: 16] == chk_exp));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(rst_lines));

    p_zero_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[31:16] == 16'h0) |=> $stable(rst_lines));

    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_unmapped_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> $stable(rst_lines));

    p_unmapped_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |=> (bus_rdata == 32'h0));

    p_one_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> ($countones(rst_lines ^ $past(rst_lines)) <= 16));
endmodule

bind hwmask_reset_bank hwrb_checker #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_lines(rst_lines)
);

// File: tb/hwmask_reset_bank_tb.sv
`timescale 1ns/1ps
module hwmask_reset_bank_tb;
    localparam int NREG = 10;
    localparam int AW   = 6;
    localparam int NL   = NREG * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] rst_lines;

    logic [NL-1:0] model;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hwmask_reset_bank #(.NUM_REGS(NREG), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_lines(rst_lines)
    );

    function automatic bit is_mapped(input logic [AW-1:0] a);
        return (a[1:0] == 2'b00) && (int'(a >> 2) < NREG);
    endfunction

    function automatic logic [NL-1:0] apply_wr(input logic [NL-1:0] m,
                                               input logic [AW-1:0] a,
                                               input logic [31:0] d);
        logic [NL-1:0] r = m;
        if (is_mapped(a)) begin
            for (int i = 0; i < 16; i++) begin
                if (d[16+i]) r[int'(a >> 2)*16 + i] = d[i];
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [NL-1:0] m, input logic [AW-1:0] a);
        if (!is_mapped(a)) return 32'h0;
        return {16'h0, m[int'(a >> 2)*16 +: 16]};
    endfunction

    task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model = apply_wr(model, a, d);
        chk(req, rst_lines, model);
    endtask

    task automatic do_rd(input logic [AW-1:0] a, input string req);
        logic [31:0] e;
        e = exp_rd(model, a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, NL'(bus_rdata), NL'(e));
    endtask

    task automatic do_rw(input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] e;
        e = exp_rd(model, a);
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        model = apply_wr(model, a, d);
        chk("R10 read data", NL'(bus_rdata), NL'(e));
        chk("R10 lines", rst_lines, model);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [AW-1:0] a;
        logic [31:0]   d;
        int            k;
        void'($urandom(32'h5EED_0042));
        model = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset lines", rst_lines, '0);
        chk("R1 reset rdata", NL'(bus_rdata), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", rst_lines, '0);

        // R2: single lines at scattered indices
        foreach (k_list[j]) begin
            k = k_list[j];
            do_wr(AW'((k / 16) * 4), 32'h1 << (16 + k % 16) | 32'h1 << (k % 16), "R2 line set");
            chk("R2 exact bit", rst_lines, NL'(1) << k);
            do_wr(AW'((k / 16) * 4), 32'h1 << (16 + k % 16), "R2 line clear");
        end

        // R3 masked update
        do_wr(6'h08, 32'hFFFF_5A5A, "R3 full write");
        do_wr(6'h08, 32'h00F0_00A5, "R3 partial write");
        // R4 zero enables
        do_wr(6'h08, 32'h0000_FFFF, "R4 zero mask");
        // R8 neighbour word
        do_wr(6'h0C, 32'hFFFF_1234, "R8 other word");
        do_rd(6'h08, "R5 read word2");
        do_rd(6'h0C, "R5 read word3");
        // R6 unmapped writes
        do_wr(6'h09, 32'hFFFF_FFFF, "R6 misaligned");
        do_wr(6'h28, 32'hFFFF_FFFF, "R6 index 10");
        do_wr(6'h3C, 32'hFFFF_FFFF, "R6 index 15");
        // R7 unmapped read after a nonzero read
        do_rd(6'h0C, "R5 read before unmapped");
        do_rd(6'h2C, "R7 unmapped read");
        do_rd(6'h0E, "R7 misaligned read");
        // R9 restart sequence
        do_wr(6'h00, 32'hFFFE_ABCC, "R9 preset word0");
        do_wr(6'h00, 32'h0001_0001, "R9 assert line0");
        chk("R9 line0 high", NL'(rst_lines[0]), NL'(1));
        do_wr(6'h00, 32'h0001_0000, "R9 release line0");
        chk("R9 line0 low", NL'(rst_lines[0]), NL'(0));
        // R10 read with write
        do_rw(6'h08, 32'hFFFF_0F0F);

        // random mix
        for (int n = 0; n < 600; n++) begin
            a = AW'($urandom_range(0, 63));
            if ($urandom_range(0, 2) != 0) a[1:0] = 2'b00;
            d = $urandom();
            case ($urandom_range(0, 5))
                0: d[31:16] = 16'h0;
                1: d[31:16] = 16'hFFFF;
                default: ;
            endcase
            case ($urandom_range(0, 3))
                0: do_rd(a, "R5 random read");
                1: do_rw(a, d);
                default: do_wr(a, d, "R3 random write");
            endcase
        end
        for (int r = 0; r < NREG; r++) do_rd(AW'(r * 4), "R5 final sweep");

        done = 1'b1;
        finish_run();
    end

    int k_list [4] = '{0, 17, 85, 159};
endmodule